// File: doc/BRIEF.md
# External-Port DMA Channel Controller with Port FIFO

This block holds the control and status logic of one external-port DMA channel. Software writes a control word and three sequence parameters (address index, address step and word count) over a simple single-cycle register bus. The control word is not applied at once. It passes through a fixed pipeline, so the channel sees new mode bits one edge after the register holds them. The FIFO flush request travels one stage further than the mode bits.

The channel includes a small port FIFO, two words deep by default. Its fill level is reported as a two-bit code, both on a port and inside the control-word readback. Each word popped while the channel is enabled counts as one transferred word. That word lowers the count and advances the index by the step. When the count reaches zero, the enable bit clears by itself.

While the stored enable bit is set, writes to the sequence parameters are dropped. Software must therefore disable the channel, reload the parameters and enable it again. An optional interrupt gives a one-cycle pulse for every word that enters or leaves the FIFO.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the control readback, index, step and count all read 0. `act_ctl` is 0, `fifo_status` is 00 and `irq` is 0.
- R2: A control write sampled at clock edge N shows in the register readback after edge N. It drives `act_ctl` only after edge N+1, and `act_ctl` still holds its old value between those two edges.
- R3: Writing 1 to control bit 7 empties the FIFO at edge N+2, where N is the edge that samples the write. The FIFO is not emptied before that edge. Bit 7 always reads back as 0.
- R4: `fifo_status` (also readback bits 9:8) is 00 when the FIFO is empty, 10 when it holds some words and 11 when it is full. The code 01 never appears.
- R5: The FIFO returns words in the order they were pushed. A push while full is ignored, even when a pop happens in the same cycle. A pop while empty is ignored.
- R6: The control bits are: 0 channel enable, 1 chaining enable, 2 direction (1 = toward external memory), 3 bus master, 4 handshake, 5 external device to memory, 6 per-word interrupt. `act_ctl[6:0]` uses the same bit order. Bits 10 to 31 read 0, and written values in bits 8 to 31 have no effect on the control readback.
- R7: Register address 0 is control, 1 is index, 2 is step and 3 is count. Writes to addresses 1 to 3 are ignored while the stored enable bit (readback bit 0) is 1, and are accepted while it is 0.
- R8: A pop accepted while `act_ctl[0]` is 1 and the count is not zero lowers the count by 1 and adds the step to the index. Pops made while the channel is disabled change neither value.
- R9: When a transfer brings the count to 0, readback bit 0 and `act_ctl[0]` are both 0 after that same edge.
- R10: While `act_ctl[6]` is 1, each accepted push or pop gives `irq` high for exactly the one cycle after the edge that accepted it. While `act_ctl[6]` is 0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 index, 2 step, 3 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of the selected register |
| fifo_push | input | 1 | Push `push_data` into the FIFO |
| push_data | input | DW | Word to push |
| fifo_pop | input | 1 | Pop the head word |
| pop_data | output | DW | Head word of the FIFO |
| fifo_status | output | 2 | Fill code: 00 empty, 10 partly full, 11 full |
| irq | output | 1 | Per-word interrupt pulse |
| act_ctl | output | 7 | Applied control bits, same order as the register |

## Verification
A table of control words runs through the write pipeline. It mixes single bits, all bits set together with junk in the upper bits, and a clear word. It checks the bit map and also the one-edge lag between the readback and the applied bits. Directed FIFO sequences do the following:
- fill the FIFO to full and overfill it, then drain it and over-drain it, which separates the three status codes and the dropped operations;
- flush a full FIFO, which separates the third-edge action from an earlier one.

A three-word transfer run, made with the interrupt enabled, shows the count and index stepping and the self-clearing enable. Parameter writes made before and after enabling show the lock.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int CTL_BITS  = 7;
    localparam int FLUSH_BIT = 7;

    typedef enum logic [1:0] {
        ADR_CTL    = 2'd0,
        ADR_INDEX  = 2'd1,
        ADR_MODIFY = 2'd2,
        ADR_COUNT  = 2'd3
    } reg_addr_e;

    // Field order gives bit 0 = enable ... bit 6 = per-word interrupt
    typedef struct packed {
        logic intio;
        logic extdev;
        logic hshake;
        logic master;
        logic dir;
        logic chain;
        logic en;
    } ctl_t;

    localparam logic [1:0] FS_EMPTY = 2'b00;
    localparam logic [1:0] FS_PART  = 2'b10;
    localparam logic [1:0] FS_FULL  = 2'b11;

endpackage

// File: rtl/dma_port_fifo.sv
module dma_port_fifo
    import dma_chan_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic [1:0]   status,
    output logic         push_ok,
    output logic         pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           fill;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.fill != FULL) && !flush;
        pop_ok  = pop && (st_q.fill != '0) && !flush;
        if (flush) begin
            st_d.rd   = '0;
            st_d.wr   = '0;
            st_d.fill = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = wdata;
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (pop_ok) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.fill = st_q.fill + 1'b1;
                2'b01:   st_d.fill = st_q.fill - 1'b1;
                default: st_d.fill = st_q.fill;
            endcase
        end
        rdata = st_q.mem[st_q.rd];
        if (st_q.fill == '0)       status = FS_EMPTY;
        else if (st_q.fill == FULL) status = FS_FULL;
        else                        status = FS_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FULL); // R5
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b01); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.fill == '0)); // R3

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_chan_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CNW = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    input  logic        push_ok,
    input  logic        pop_ok,
    input  logic [1:0]  fifo_status,
    output logic [31:0] rdata,
    output ctl_t        act,
    output logic        flush_now,
    output logic        irq
);
    typedef struct packed {
        ctl_t           ctl;
        ctl_t           act;
        logic           fl1;
        logic           fl2;
        logic [AW-1:0]  idx;
        logic [AW-1:0]  mod;
        logic [CNW-1:0] cnt;
        logic           irq;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    xfer;

    always_comb begin
        st_d     = st_q;
        st_d.act = st_q.ctl;
        st_d.fl1 = wr && (addr == ADR_CTL) && wdata[FLUSH_BIT];
        st_d.fl2 = st_q.fl1;
        st_d.irq = st_q.act.intio && (push_ok || pop_ok);
        xfer     = pop_ok && st_q.act.en && (st_q.cnt != '0);
        if (xfer) begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.idx = st_q.idx + st_q.mod;
            if (st_q.cnt == CNW'(1)) begin
                st_d.ctl.en = 1'b0;
                st_d.act.en = 1'b0;
            end
        end
        if (wr) begin
            case (reg_addr_e'(addr))
                ADR_CTL:    st_d.ctl = ctl_t'(wdata[CTL_BITS-1:0]);
                ADR_INDEX:  if (!st_q.ctl.en) st_d.idx = wdata[AW-1:0];
                ADR_MODIFY: if (!st_q.ctl.en) st_d.mod = wdata[AW-1:0];
                ADR_COUNT:  if (!st_q.ctl.en) st_d.cnt = wdata[CNW-1:0];
                default:    ;
            endcase
        end
        case (reg_addr_e'(addr))
            ADR_CTL:    rdata = {22'd0, fifo_status, 1'b0, st_q.ctl};
            ADR_INDEX:  rdata = 32'(st_q.idx);
            ADR_MODIFY: rdata = 32'(st_q.mod);
            default:    rdata = 32'(st_q.cnt);
        endcase
        act       = st_q.act;
        flush_now = st_q.fl2;
        irq       = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_APPLY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_CTL) |=> ##1 (st_q.act.dir == $past(wdata[2], 2))); // R2
    AST_PARAM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_MODIFY && st_q.ctl.en) |=> $stable(st_q.mod)); // R7
    AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && st_q.cnt == CNW'(1) && !(wr && addr == ADR_CTL))
            |=> (!st_q.act.en && !st_q.ctl.en)); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(st_q.act.intio)); // R10

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    parameter int AW    = 32,
    parameter int CNW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          fifo_push,
    input  logic [DW-1:0] push_data,
    input  logic          fifo_pop,
    output logic [DW-1:0] pop_data,
    output logic [1:0]    fifo_status,
    output logic          irq,
    output logic [6:0]    act_ctl
);
    logic push_ok, pop_ok, flush_now;
    ctl_t act;

    dma_port_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_now),
        .push    (fifo_push),
        .wdata   (push_data),
        .pop     (fifo_pop),
        .rdata   (pop_data),
        .status  (fifo_status),
        .push_ok (push_ok),
        .pop_ok  (pop_ok)
    );

    dma_ctl_regs #(.AW(AW), .CNW(CNW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .push_ok     (push_ok),
        .pop_ok      (pop_ok),
        .fifo_status (fifo_status),
        .rdata       (reg_rdata),
        .act         (act),
        .flush_now   (flush_now),
        .irq         (irq)
    );

    assign act_ctl = act;

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_push = 1'b0;
    logic [31:0] push_data = '0;
    logic        fifo_pop = 1'b0;
    logic [31:0] pop_data;
    logic [1:0]  fifo_status;
    logic        irq;
    logic [6:0]  act_ctl;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_chan_ctl u_dma_chan_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_push(fifo_push),
        .push_data(push_data), .fifo_pop(fifo_pop), .pop_data(pop_data),
        .fifo_status(fifo_status), .irq(irq), .act_ctl(act_ctl)
    );

    localparam int NV = 6;
    localparam logic [31:0] VEC_W [NV] = '{32'h0000_0001, 32'h0000_0006,
        32'hFFFF_FF7F, 32'h0000_0328, 32'hA5A5_0050, 32'h0000_0000};
    localparam logic [31:0] VEC_R [NV] = '{32'h01, 32'h06, 32'h7F, 32'h28,
        32'h50, 32'h00};

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        fifo_push = 1'b1; push_data = d;
        step();
        fifo_push = 1'b0;
    endtask

    task automatic pop();
        fifo_pop = 1'b1;
        step();
        fifo_pop = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [6:0]  prev;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rreg(2'(a), r);
            check("R1 readback", r, 32'h0);
        end
        check("R1 act_ctl", 32'(act_ctl), 32'h0);
        check("R1 status", 32'(fifo_status), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 / R6 vector table
        prev = act_ctl;
        for (int i = 0; i < NV; i++) begin
            wreg(2'd0, VEC_W[i]);
            rreg(2'd0, r);
            check("R6 ctl readback", r, VEC_R[i]);
            check("R2 act not yet applied", 32'(act_ctl), 32'(prev));
            step();
            check("R2 act applied", 32'(act_ctl), VEC_R[i]);
            prev = act_ctl;
        end

        // R4 / R5 FIFO fill and drain, interrupt off
        push(32'hAAAA_0001);
        check("R4 partial", 32'(fifo_status), 32'b10);
        check("R10 irq off", 32'(irq), 32'h0);
        push(32'hAAAA_0002);
        check("R4 full", 32'(fifo_status), 32'b11);
        fifo_pop = 1'b1;
        push(32'hAAAA_0003);
        fifo_pop = 1'b0;
        check("R5 push while full dropped", 32'(fifo_status), 32'b10);
        check("R5 order", pop_data, 32'hAAAA_0002);
        pop();
        check("R4 empty", 32'(fifo_status), 32'b00);
        pop();
        check("R5 pop while empty", 32'(fifo_status), 32'b00);
        rreg(2'd0, r);
        check("R4 status in readback", r & 32'h300, 32'h0);

        // R3 flush timing
        push(32'h1); push(32'h2);
        wreg(2'd0, 32'h80);
        check("R3 not after 1st edge", 32'(fifo_status), 32'b11);
        rreg(2'd0, r);
        check("R3 bit7 reads 0 (R6 status 11)", r, 32'h300);
        step();
        check("R3 not after 2nd edge", 32'(fifo_status), 32'b11);
        step();
        check("R3 empty after 3rd edge", 32'(fifo_status), 32'b00);

        // R7 parameter lock
        wreg(2'd1, 32'd100);
        wreg(2'd2, 32'd4);
        wreg(2'd3, 32'd3);
        rreg(2'd1, r); check("R7 index loaded", r, 32'd100);
        rreg(2'd2, r); check("R7 step loaded", r, 32'd4);
        rreg(2'd3, r); check("R7 count loaded", r, 32'd3);
        wreg(2'd0, 32'h41);
        wreg(2'd1, 32'd999);
        wreg(2'd2, 32'd7);
        rreg(2'd1, r); check("R7 index locked", r, 32'd100);
        rreg(2'd2, r); check("R7 step locked", r, 32'd4);
        check("R2 act enabled", 32'(act_ctl), 32'h41);

        // R8 / R9 / R10 transfers
        push(32'hB1);
        check("R10 irq on push", 32'(irq), 32'h1);
        step();
        check("R10 irq one cycle", 32'(irq), 32'h0);
        push(32'hB2);
        pop();
        check("R10 irq on pop", 32'(irq), 32'h1);
        rreg(2'd3, r); check("R8 count 2", r, 32'd2);
        rreg(2'd1, r); check("R8 index 104", r, 32'd104);
        pop();
        rreg(2'd3, r); check("R8 count 1", r, 32'd1);
        rreg(2'd1, r); check("R8 index 108", r, 32'd108);
        push(32'hB3);
        pop();
        rreg(2'd3, r); check("R9 count 0", r, 32'd0);
        rreg(2'd1, r); check("R8 index 112", r, 32'd112);
        rreg(2'd0, r); check("R9 enable cleared", r & 32'h1, 32'h0);
        check("R9 act enable cleared", 32'(act_ctl) & 32'h1, 32'h0);
        wreg(2'd3, 32'd5);
        push(32'hB4);
        pop();
        rreg(2'd3, r); check("R8 no transfer while disabled", r, 32'd5);
        rreg(2'd1, r); check("R8 index held while disabled", r, 32'd112);

        // R1 reset again
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        rreg(2'd3, r); check("R1 count after reset", r, 32'h0);
        check("R1 act after reset", 32'(act_ctl), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule